// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block builds the interrupt request for a synchronous serial port whose transmit and receive FIFOs hold eight entries each. The FIFOs, the shift engine and the DMA engine sit outside it. Only their status comes in: the two fill levels, a receive-empty flag, a strobe for each received frame, a tick at the serial bit rate, and one done pulse from each DMA direction. From these it forms six interrupt sources. Each source has a raw status bit, a mask bit and a masked status bit. All masked bits are ORed onto one interrupt line.

Two sources follow the FIFO levels directly. The receive request is high while the receive FIFO holds at least four entries. The transmit request is high while the transmit FIFO holds at most four entries. The transmit request is not qualified by any port enable, so software can preload the FIFO before the port is switched on.

The other four sources are sticky flags:
- The overrun flag is set when a frame arrives into a full receive FIFO. For that frame the FIFO write enable is withheld, so only the shift register is overwritten.
- The idle-timeout flag comes from a small state machine with three states:
  - `TMR_IDLE`: the receive FIFO is empty.
  - `TMR_COUNT`: counting bit ticks. It is entered by the transition IDLE→COUNT when the FIFO becomes non-empty. The transition COUNT→IDLE happens when the FIFO drains.
  - `TMR_EXPIRED`: reached by the transition COUNT→EXPIRED on the 32nd tick, which also sets the flag. The transition EXPIRED→IDLE happens when the FIFO drains.
- The two DMA-done flags latch their done pulses.

A simple register port selects one of four registers: raw status, mask, masked status and clear.

Top module: `sport_irq_ctrl`

## Requirements
- R1: Raw status bit 0 (receive level request) equals 1 exactly when `rx_level` is 4 or more.
- R2: Raw status bit 1 (transmit level request) equals 1 exactly when `tx_level` is 4 or less. No other input affects it.
- R3: A `rx_frame` strobe while `rx_level` equals 8 sets raw bit 3 (overrun) at that clock edge, and `rx_wr_en` is 0 for that frame. `rx_wr_en` is 1 for a frame arriving when `rx_level` is below 8.
- R4: When `rx_empty` falls, the timer leaves IDLE at the next edge. Raw bit 2 (idle timeout) is set at the edge that samples the 32nd `bit_tick` after that. Ticks are counted whether or not frames are arriving.
- R5: If `rx_empty` is seen high before the 32nd tick, the count returns to zero and no flag is raised. A later fill again needs a full 32 ticks.
- R6: Writing register 3 (clear) with 1 in bit 2, 3, 4 or 5 clears that sticky flag. Bits 0 and 1 ignore clear writes. A set event in the same cycle as its clear leaves the flag set.
- R7: Raw bit 4 latches on a `dma_rx_done` pulse and raw bit 5 latches on a `dma_tx_done` pulse.
- R8: Mask bits 0 to 3 enable their sources when 1. Mask bits 4 and 5 enable their sources when 0. The mask resets to 0.
- R9: The masked status equals raw status ANDed with the effective enables, and `irq` is the OR of the masked status bits.
- R10: After reset all sticky flags are 0, the mask is 0 and the timer is in IDLE.
- R11: `reg_sel` selects what `reg_rdata` returns: 0 gives raw status, 1 gives the mask (written when `reg_wr` is high), 2 gives masked status, and 3 is the write-only clear register, which reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 4 | Receive FIFO fill level, 0 to 8 |
| tx_level | input | 4 | Transmit FIFO fill level, 0 to 8 |
| rx_empty | input | 1 | Receive FIFO empty flag |
| rx_frame | input | 1 | One-cycle strobe: a frame has been received |
| bit_tick | input | 1 | One-cycle tick at the serial bit rate |
| dma_rx_done | input | 1 | Receive DMA done pulse |
| dma_tx_done | input | 1 | Transmit DMA done pulse |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data (combinational) |
| rx_wr_en | output | 1 | Receive FIFO write enable for the current frame |
| irq | output | 1 | Merged interrupt request |

## Verification
A wrong timer state or count shows up as raw bit 2 rising one or more ticks too early or too late, or never rising after a drain and refill. A reference counter in the bench exposes this in the very cycle after the faulty edge. A stuck or wrongly cleared sticky flag is seen at the next read of raw or masked status and on `irq` in the same cycle, because every output is combinational from the registers. An inverted mask polarity shows immediately as a wrong `irq` whenever a DMA flag is set.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE    = 2'd0,
        TMR_COUNT   = 2'd1,
        TMR_EXPIRED = 2'd2
    } tmr_state_t;

    localparam int BIT_RXLVL = 0;
    localparam int BIT_TXLVL = 1;
    localparam int BIT_TMO   = 2;
    localparam int BIT_OVR   = 3;
    localparam int BIT_DRX   = 4;
    localparam int BIT_DTX   = 5;
    localparam int NSRC      = 6;

    localparam logic [1:0] SEL_RAW  = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_MIS  = 2'd2;
    localparam logic [1:0] SEL_CLR  = 2'd3;

endpackage

// File: rtl/sport_sticky_flag.sv
module sport_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Set has priority over clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/sport_rx_idle_timer.sv
module sport_rx_idle_timer
    import sport_irq_pkg::*;
#(
    parameter int TO_TICKS = 32,
    localparam int CW = $clog2(TO_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          empty_i,
    input  logic          tick_i,
    output logic          expire_o,
    output logic [CW-1:0] cnt_o
);
    tmr_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (empty_i) begin
            st_d  = TMR_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TMR_IDLE: begin
                    st_d  = TMR_COUNT;
                    cnt_d = '0;
                end
                TMR_COUNT: begin
                    if (tick_i) begin
                        if (cnt_q == CW'(TO_TICKS - 1)) begin
                            st_d     = TMR_EXPIRED;
                            expire_o = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TMR_EXPIRED: st_d = TMR_EXPIRED;
                default:     st_d = TMR_IDLE;
            endcase
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sport_irq_ctrl.sv
module sport_irq_ctrl
    import sport_irq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int RX_THR   = 4,
    parameter int TX_THR   = 4,
    parameter int TO_TICKS = 32,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(TO_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] tx_level,
    input  logic          rx_empty,
    input  logic          rx_frame,
    input  logic          bit_tick,
    input  logic          dma_rx_done,
    input  logic          dma_tx_done,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic          rx_wr_en,
    output logic          irq
);
    logic [NSRC-1:0] raw_stat;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] enab;
    logic [NSRC-1:0] mis;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic            rx_full;
    logic            tmr_expire;
    logic [CW-1:0]   tmr_cnt;

    assign rx_full  = (rx_level == LW'(DEPTH));
    assign rx_wr_en = rx_frame & ~rx_full;

    // Level-driven sources
    assign raw_stat[BIT_RXLVL] = (rx_level >= LW'(RX_THR));
    assign raw_stat[BIT_TXLVL] = (tx_level <= LW'(TX_THR));

    sport_rx_idle_timer #(.TO_TICKS(TO_TICKS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .empty_i  (rx_empty),
        .tick_i   (bit_tick),
        .expire_o (tmr_expire),
        .cnt_o    (tmr_cnt)
    );

    always_comb begin
        set_v            = '0;
        set_v[BIT_TMO]   = tmr_expire;
        set_v[BIT_OVR]   = rx_frame & rx_full;
        set_v[BIT_DRX]   = dma_rx_done;
        set_v[BIT_DTX]   = dma_tx_done;
        clr_v            = (reg_wr && reg_sel == SEL_CLR) ? reg_wdata : '0;
    end

    // Sticky sources
    for (genvar g = BIT_TMO; g < NSRC; g++) begin : g_flag
        sport_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (raw_stat[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_q <= '0;
        else if (reg_wr && reg_sel == SEL_MASK)  mask_q <= reg_wdata;
    end

    // DMA masks are block-when-set; the others enable-when-set.
    always_comb begin
        enab          = mask_q;
        enab[BIT_DRX] = ~mask_q[BIT_DRX];
        enab[BIT_DTX] = ~mask_q[BIT_DTX];
    end

    assign mis = raw_stat & enab;
    assign irq = |mis;

    always_comb begin
        unique case (reg_sel)
            SEL_RAW:  reg_rdata = raw_stat;
            SEL_MASK: reg_rdata = mask_q;
            SEL_MIS:  reg_rdata = mis;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sport_irq_chk.sv
module sport_irq_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] rx_level,
    input logic          rx_empty,
    input logic          rx_frame,
    input logic          dma_rx_done,
    input logic [1:0]    reg_sel,
    input logic          reg_wr,
    input logic [5:0]    reg_wdata,
    input logic          rx_wr_en,
    input logic [5:0]    raw,
    input logic [CW-1:0] tmr_cnt
);
    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame && rx_level == LW'(DEPTH)) |=> raw[3]);

    assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == LW'(DEPTH)) |-> !rx_wr_en);

    assert_drain_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |=> (tmr_cnt == '0));

    assert_to_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[2] && !(reg_wr && reg_sel == 2'd3 && reg_wdata[2])) |=> raw[2]);

    assert_dma_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_done |=> raw[4]);
endmodule

bind sport_irq_ctrl sport_irq_chk #(.DEPTH(DEPTH), .LW(LW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_level    (rx_level),
    .rx_empty    (rx_empty),
    .rx_frame    (rx_frame),
    .dma_rx_done (dma_rx_done),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .rx_wr_en    (rx_wr_en),
    .raw         (raw_stat),
    .tmr_cnt     (tmr_cnt)
);

// File: tb/sim_sport_irq_ctrl.sv
module sim_sport_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_level = '0, tx_level = '0;
    logic       rx_empty = 1'b1, rx_frame = 1'b0, bit_tick = 1'b0;
    logic       dma_rx_done = 1'b0, dma_tx_done = 1'b0;
    logic [1:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic       rx_wr_en, irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // model state
    logic [5:0] m_mask;
    logic [5:2] m_flag;
    int         m_st, m_cnt;

    always #4 clk = ~clk;

    sport_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .rx_empty(rx_empty), .rx_frame(rx_frame), .bit_tick(bit_tick),
        .dma_rx_done(dma_rx_done), .dma_tx_done(dma_tx_done),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_wr_en(rx_wr_en), .irq(irq)
    );

    function automatic logic [5:0] exp_raw();
        return {m_flag, (tx_level <= 4), (rx_level >= 4)};
    endfunction

    function automatic logic [5:0] exp_mis();
        logic [5:0] en;
        en = {~m_mask[5:4], m_mask[3:0]};
        return exp_raw() & en;
    endfunction

    function automatic logic [5:0] exp_rd();
        case (reg_sel)
            2'd0: return exp_raw();
            2'd1: return m_mask;
            2'd2: return exp_mis();
            default: return 6'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = '0; m_flag = '0; m_st = 0; m_cnt = 0;
    endtask

    task automatic model_edge();
        logic [5:0] clr;
        logic [5:2] setv;
        bit exp_to;
        clr = (reg_wr && reg_sel == 2'd3) ? reg_wdata : 6'd0;
        exp_to = (m_st == 1) && !rx_empty && bit_tick && (m_cnt == 31);
        setv = {dma_tx_done, dma_rx_done, rx_frame && (rx_level == 8), exp_to};
        m_flag = setv | (m_flag & ~clr[5:2]);
        if (reg_wr && reg_sel == 2'd1) m_mask = reg_wdata;
        if (rx_empty) begin m_st = 0; m_cnt = 0; end
        else if (m_st == 0) begin m_st = 1; m_cnt = 0; end
        else if (m_st == 1 && bit_tick) begin
            if (m_cnt == 31) m_st = 2; else m_cnt++;
        end
    endtask

    // Inputs are set just after a negedge; compare, then advance one edge.
    task automatic cycle();
        string rt [6] = '{"R1", "R2", "R4", "R3", "R7", "R7"};
        #2;
        if (reg_sel == 2'd0) begin
            for (int b = 0; b < 6; b++) chk(rt[b], {5'd0, reg_rdata[b]}, {5'd0, exp_raw()[b]});
        end else if (reg_sel == 2'd1) chk("R8 mask read", reg_rdata, exp_rd());
        else if (reg_sel == 2'd2)     chk("R9 masked read", reg_rdata, exp_rd());
        else                          chk("R11 clear reads zero", reg_rdata, exp_rd());
        chk("R9 irq", {5'd0, irq}, {5'd0, |exp_mis()});
        chk("R3 write enable", {5'd0, rx_wr_en}, {5'd0, rx_frame && rx_level != 8});
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        rx_frame = 0; bit_tick = 0; dma_rx_done = 0; dma_tx_done = 0; reg_wr = 0;
    endtask

    task automatic set_rx(int lv);
        rx_level = 4'(lv); rx_empty = (lv == 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        tx_level = 4'd8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        reg_sel = 2'd0; #2;
        chk("R10 raw after reset", reg_rdata, 6'd0);
        chk("R10 irq after reset", {5'd0, irq}, 6'd0);
        reg_sel = 2'd1; #1;
        chk("R10 mask after reset", reg_rdata, 6'd0);
        @(negedge clk);

        // R4 exact timeout
        reg_sel = 2'd0; set_rx(1); bit_tick = 1;
        repeat (32) cycle();
        #1 chk("R4 no flag at 31 ticks", {5'd0, reg_rdata[2]}, 6'd0);
        cycle();
        #1 chk("R4 flag at 32 ticks", {5'd0, reg_rdata[2]}, 6'd1);
        // clear it (R6), then R5 drain restart
        reg_sel = 2'd3; reg_wr = 1; reg_wdata = 6'h04; cycle();
        reg_wr = 0; reg_sel = 2'd0;
        #1 chk("R6 timeout cleared", {5'd0, reg_rdata[2]}, 6'd0);
        set_rx(0); cycle();
        set_rx(2); repeat (20) cycle();
        set_rx(0); cycle();
        set_rx(2); repeat (31) cycle();
        #1 chk("R5 restart after drain", {5'd0, reg_rdata[2]}, 6'd0);
        repeat (2) cycle();
        #1 chk("R5 full count after refill", {5'd0, reg_rdata[2]}, 6'd1);
        bit_tick = 0;

        // R3 overrun
        set_rx(8); rx_frame = 1; #1;
        chk("R3 no write when full", {5'd0, rx_wr_en}, 6'd0);
        cycle(); rx_frame = 0;
        #1 chk("R3 overrun set", {5'd0, reg_rdata[3]}, 6'd1);
        set_rx(7); rx_frame = 1; #1;
        chk("R3 write when not full", {5'd0, rx_wr_en}, 6'd1);
        cycle(); rx_frame = 0;

        // R6 set wins over clear; level bits ignore clear
        set_rx(5); dma_rx_done = 1; reg_sel = 2'd3; reg_wr = 1; reg_wdata = 6'h13; cycle();
        idle_in(); reg_sel = 2'd0;
        #1 chk("R6 set beats clear", {5'd0, reg_rdata[4]}, 6'd1);
        chk("R6 level bit ignores clear", {5'd0, reg_rdata[0]}, 6'd1);
        reg_sel = 2'd3; reg_wr = 1; reg_wdata = 6'h3F; cycle();
        reg_wr = 0; reg_sel = 2'd0;
        #1 chk("R6 all sticky cleared", {2'd0, reg_rdata[5:2]}, 6'd0);

        // R8 DMA mask polarity
        tx_level = 4'd8; set_rx(1); dma_tx_done = 1; cycle(); dma_tx_done = 0;
        #1 chk("R8 dma enabled at mask 0", {5'd0, irq}, 6'd1);
        reg_sel = 2'd1; reg_wr = 1; reg_wdata = 6'h20; cycle(); reg_wr = 0;
        #1 chk("R8 dma blocked at mask 1", {5'd0, irq}, 6'd0);
        reg_sel = 2'd1; reg_wr = 1; reg_wdata = 6'h22; tx_level = 4'd2; cycle(); reg_wr = 0;
        #1 chk("R2 tx request enabled", {5'd0, irq}, 6'd1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(39) == 0) set_rx($urandom_range(8));
            if ($urandom_range(9) == 0) tx_level = 4'($urandom_range(8));
            rx_frame    = ($urandom_range(7) == 0);
            bit_tick    = $urandom_range(1);
            dma_rx_done = ($urandom_range(29) == 0);
            dma_tx_done = ($urandom_range(29) == 0);
            reg_sel     = 2'($urandom_range(3));
            reg_wr      = ($urandom_range(9) == 0);
            reg_wdata   = 6'($urandom_range(63));
            cycle();
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule